// File: doc/BRIEF.md
# Square-Wave Interval Timer

This block is one programmable counter that divides a slow timebase into a square wave. The timebase comes in as a one-clock enable pulse. Each such pulse is one timebase tick. A host programs the counter over a small byte-wide write bus with a 2-bit address, a write strobe and 8 data bits.

Programming takes two steps. The host first writes a control byte that selects square-wave operation. It then writes the 16-bit reload count as two bytes to the data address, low byte first. After the second byte the output toggles so that one full period lasts exactly as many ticks as the reload count. When the count is odd, the high half is one tick longer than the low half.

Each low-to-high transition of the wave also produces a single-clock pulse that can serve as a periodic interrupt request. A new count written while the counter runs is picked up at the next half-period boundary. The current half is not cut short.

Top module: `sqwave_timer`

## Requirements
- R1: After reset the wave output is high and the tick output is low. The counter is stopped, so timebase ticks leave the wave high until a count has been loaded.
- R2: A control byte written to address 3 is accepted only if all three of these hold: bits 7:6 = 00 (channel zero), bits 5:4 = 11 (low byte then high byte), and bits 3:1 = 011 (square wave). Bit 0 has no effect. Any other control byte is ignored, and a running count continues undisturbed.
- R3: Address 0 takes the count as two consecutive byte writes, low byte first, high byte second. Writes to addresses 1 and 2 are ignored.
- R4: Counting begins with the first timebase tick after the high byte is written. The wave is high for the first half of the period, then low.
- R5: For an even count N, the wave is high for N/2 ticks and then low for N/2 ticks.
- R6: For an odd count N, the wave is high for (N+1)/2 ticks and then low for (N-1)/2 ticks.
- R7: A count of 0 acts as 65536, which gives 32768 ticks high and 32768 ticks low. A count of 1 acts as 2.
- R8: An accepted control byte stops the counter at once and forces the wave high. It also returns the byte sequencer to expect a low byte. No tick pulse results from it.
- R9: A count written while the counter runs leaves the current half-period unchanged. The new count sets the length of the halves that follow.
- R10: The tick output is high for exactly one clock on each low-to-high transition of the wave produced by counting, and is low at all other times.
- R11: The wave output changes only on a clock in which the timebase enable is high, or on an accepted control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_en | input | 1 | Timebase enable; one clock per timebase tick |
| bus_addr | input | 2 | Register address: 0 is the count, 3 is the control byte |
| bus_wr | input | 1 | Write strobe, one clock per byte |
| bus_wdata | input | 8 | Write data byte |
| wave_out | output | 1 | Square-wave output |
| tick_pulse | output | 1 | One-clock pulse on each rising edge of the wave |

## Verification
The bench measures every half-period in timebase ticks and compares it with a queue of expected lengths. The cases are:
- Even, odd, unit and zero counts. A design that splits an odd count the wrong way round, or wraps a zero count to a short period, gives the wrong lengths.
- A new count written one tick into a high half. If the design applied the count immediately, that half would stretch to the new length.
- Ignored control bytes and writes to the unused addresses in the middle of a run. If the design acted on them, the run would stall or the period would change.
- A control byte written after only a low byte. If the sequencer were not reset, the next low byte would be taken as a high byte.
- A stop while the wave is low. Here the wave must return high with no tick pulse and stay there.

// File: rtl/sqt_pkg.sv
package sqt_pkg;

  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [1:0] chan;
    logic [1:0] access;
    logic [2:0] opmode;
    logic       decimal;
  } sqt_ctrl_t;

  localparam logic [1:0] CHAN_ZERO   = 2'b00;
  localparam logic [1:0] ACCESS_LOHI = 2'b11;
  localparam logic [2:0] OP_SQUARE   = 3'b011;

  // Only channel zero, low-then-high access and square wave are built;
  // the decimal bit is deliberately left out of the match.
  function automatic logic ctrl_supported(sqt_ctrl_t c);
    return (c.chan == CHAN_ZERO) && (c.access == ACCESS_LOHI) &&
           (c.opmode == OP_SQUARE);
  endfunction

endpackage

// File: rtl/sqt_regif.sv
module sqt_regif
  import sqt_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 3,
  parameter int DATA_ADDR = 0,
  localparam int CNT_W    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              ctrl_accept,
  output logic              count_commit,
  output logic [CNT_W-1:0]  count_val
);

  localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] DATA_SEL = ADDR_W'(DATA_ADDR);

  logic              hi_next;
  logic [BYTE_W-1:0] lo_q;
  logic              ctrl_hit;
  logic              data_hit;

  assign ctrl_hit     = wr_en && (addr == CTRL_SEL);
  assign data_hit     = wr_en && (addr == DATA_SEL);
  assign ctrl_accept  = ctrl_hit && ctrl_supported(sqt_ctrl_t'(wdata));
  assign count_commit = data_hit && hi_next;
  assign count_val    = {wdata, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_next <= 1'b0;
      lo_q    <= '0;
    end else if (ctrl_accept) begin
      hi_next <= 1'b0;
    end else if (data_hit) begin
      if (!hi_next) lo_q <= wdata;
      hi_next <= ~hi_next;
    end
  end

  p_ptr_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_accept |=> !hi_next);

  p_low_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && !hi_next && !ctrl_accept) |=> (hi_next && lo_q == $past(wdata)));

  p_pair_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_commit |=> !hi_next);

endmodule

// File: rtl/sqt_core.sv
module sqt_core #(
  parameter int CNT_W = 16,
  localparam int EXT_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic             ctrl_accept,
  input  logic             count_commit,
  input  logic [CNT_W-1:0] count_val,
  output logic             wave,
  output logic             tick
);

  // Effective period: 0 means the full range, 1 is raised to 2.
  function automatic logic [EXT_W-1:0] eff_count(logic [CNT_W-1:0] n);
    if (n == '0)               return EXT_W'(1) << CNT_W;
    else if (n == CNT_W'(1))   return EXT_W'(2);
    else                       return {1'b0, n};
  endfunction

  function automatic logic [CNT_W-1:0] high_len(logic [CNT_W-1:0] n);
    logic [EXT_W-1:0] e, h;
    e = eff_count(n);
    h = e - (e >> 1);
    return h[CNT_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] low_len(logic [CNT_W-1:0] n);
    logic [EXT_W-1:0] e, l;
    e = eff_count(n);
    l = e >> 1;
    return l[CNT_W-1:0];
  endfunction

  logic             running;
  logic [CNT_W-1:0] rem_q;
  logic             wave_q;
  logic             tick_q;
  logic [CNT_W-1:0] reload_q;

  // Named internal events.
  logic             tick_go;
  logic             phase_end;
  logic             rise_evt;
  logic             start_evt;
  logic [CNT_W-1:0] reload_nx;

  assign tick_go   = running && tb_en && !ctrl_accept;
  assign phase_end = tick_go && (rem_q == CNT_W'(1));
  assign rise_evt  = phase_end && !wave_q;
  assign start_evt = count_commit && !running && !ctrl_accept;
  assign reload_nx = count_commit ? count_val : reload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      rem_q    <= '0;
      wave_q   <= 1'b1;
      tick_q   <= 1'b0;
      reload_q <= '0;
    end else if (ctrl_accept) begin
      running <= 1'b0;
      rem_q   <= '0;
      wave_q  <= 1'b1;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= rise_evt;
      if (count_commit) reload_q <= count_val;
      if (start_evt) begin
        running <= 1'b1;
        rem_q   <= high_len(count_val);
      end else if (phase_end) begin
        wave_q <= ~wave_q;
        rem_q  <= wave_q ? low_len(reload_nx) : high_len(reload_nx);
      end else if (tick_go) begin
        rem_q <= rem_q - CNT_W'(1);
      end
    end
  end

  assign wave = wave_q;
  assign tick = tick_q;

  p_tick_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (wave_q && !$past(wave_q)));

  p_rise_ticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> (tick_q && wave_q));

  p_ctrl_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_accept |=> (wave_q && !running && !tick_q));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_en && !ctrl_accept) |=> $stable(wave_q));

  p_rem_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (rem_q != '0));

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> wave_q);

endmodule

// File: rtl/sqwave_timer.sv
module sqwave_timer
  import sqt_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 3,
  parameter int DATA_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic              wave_out,
  output logic              tick_pulse
);

  localparam int CNT_W = 2 * BYTE_W;

  logic             ctrl_accept;
  logic             count_commit;
  logic [CNT_W-1:0] count_val;

  sqt_regif #(
    .ADDR_W   (ADDR_W),
    .CTRL_ADDR(CTRL_ADDR),
    .DATA_ADDR(DATA_ADDR)
  ) i_regif (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (bus_wr),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .ctrl_accept (ctrl_accept),
    .count_commit(count_commit),
    .count_val   (count_val)
  );

  sqt_core #(
    .CNT_W(CNT_W)
  ) i_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tb_en       (tb_en),
    .ctrl_accept (ctrl_accept),
    .count_commit(count_commit),
    .count_val   (count_val),
    .wave        (wave_out),
    .tick        (tick_pulse)
  );

endmodule

// File: tb/test_sqwave_timer.sv
module test_sqwave_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_en = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  wire        wave_out;
  wire        tick_pulse;

  always #5 clk = ~clk;

  sqwave_timer i_sqwave_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tb_en     (tb_en),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .wave_out  (wave_out),
    .tick_pulse(tick_pulse)
  );

  typedef struct {
    bit    lvl;
    int    len;
    string tag;
  } seg_t;

  seg_t  exp_q[$];
  seg_t  got;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    mon_en = 1'b0;
  int    seg_len = 0;
  bit    prev_wave = 1'b1;
  bit    done = 1'b0;
  int    tick_seen = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: measures each half-period in ticks and pops the scoreboard.
  always @(negedge clk) begin
    if (tick_pulse === 1'b1) tick_seen++;
    if (!mon_en) begin
      seg_len = 0;
    end else begin
      if (wave_out !== prev_wave) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected wave edge", int'(wave_out), int'(prev_wave));
        end else begin
          got = exp_q.pop_front();
          check(got.lvl == prev_wave, got.tag, "half level", int'(prev_wave), int'(got.lvl));
          check(got.len == seg_len, got.tag, "half length", seg_len, got.len);
        end
        if (wave_out === 1'b1)
          check(tick_pulse === 1'b1, "R10", "tick on rise", int'(tick_pulse), 1);
        seg_len = 0;
      end else if (tick_pulse !== 1'b0) begin
        check(1'b0, "R10", "tick without rise", int'(tick_pulse), 0);
      end
      if (tb_en) seg_len++;
    end
    prev_wave = wave_out;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tb_en = 1'b1;
      @(posedge clk); #1 tb_en = 1'b0;
      repeat (gap) @(posedge clk);
    end
  endtask

  task automatic burst(input int n);
    @(posedge clk); #1 tb_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tb_en = 1'b0;
  endtask

  // Expected halves computed from the requirements.
  task automatic expect_wave(input int n, input int periods, input string tag);
    int e;
    e = (n == 0) ? 65536 : n;
    if (e == 1) e = 2;
    for (int p = 0; p < periods; p++) begin
      exp_q.push_back('{1'b1, e - e / 2, tag});
      exp_q.push_back('{1'b0, e / 2, tag});
    end
  endtask

  task automatic push_seg(input bit l, input int n, input string tag);
    exp_q.push_back('{l, n, tag});
  endtask

  task automatic start_count(input int n, input logic [7:0] ctrl);
    mon_en = 1'b0;
    wr(2'd3, ctrl);
    check(wave_out === 1'b1, "R8", "wave after control", int'(wave_out), 1);
    wr(2'd0, n[7:0]);
    wr(2'd0, n[15:8]);
    @(posedge clk); #1 mon_en = 1'b1;
  endtask

  task automatic finish_run(input string tag);
    repeat (3) @(posedge clk);
    #1;
    check(exp_q.size() == 0, tag, "halves left unseen", exp_q.size(), 0);
    exp_q.delete();
    mon_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check(wave_out === 1'b1, "R1", "wave at reset", int'(wave_out), 1);
    check(tick_pulse === 1'b0, "R1", "tick at reset", int'(tick_pulse), 0);
    ticks(8, 1);
    check(wave_out === 1'b1, "R1", "wave with no count", int'(wave_out), 1);

    // R5 even count
    start_count(6, 8'h36);
    expect_wave(6, 3, "R5");
    ticks(18, 1);
    finish_run("R5");

    // R6 odd count
    start_count(7, 8'h36);
    expect_wave(7, 2, "R6");
    ticks(14, 0);
    finish_run("R6");

    // R2 decimal bit set is ignored
    start_count(5, 8'h37);
    expect_wave(5, 2, "R2");
    ticks(10, 1);
    finish_run("R2");

    // R7 count of one acts as two
    start_count(1, 8'h36);
    expect_wave(1, 3, "R7");
    ticks(6, 2);
    finish_run("R7");

    // R11 no change without timebase ticks
    start_count(6, 8'h36);
    expect_wave(6, 1, "R11");
    ticks(1, 1);
    repeat (20) @(posedge clk);
    #1 check(wave_out === 1'b1, "R11", "wave while timebase idle", int'(wave_out), 1);
    ticks(5, 1);
    finish_run("R11");

    // R2/R3/R9 ignored bytes mid-run, then a reload taking effect later
    start_count(4, 8'h36);
    expect_wave(4, 1, "R3");
    ticks(4, 1);
    wr(2'd3, 8'h76);
    wr(2'd3, 8'h16);
    wr(2'd3, 8'h34);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hAA);
    push_seg(1'b1, 2, "R2");
    push_seg(1'b0, 4, "R9");
    push_seg(1'b1, 4, "R9");
    push_seg(1'b0, 4, "R9");
    wr(2'd0, 8'd8);
    wr(2'd0, 8'd0);
    ticks(14, 1);
    finish_run("R3");

    // R9 reload one tick into a high half
    start_count(4, 8'h36);
    push_seg(1'b1, 2, "R9");
    push_seg(1'b0, 5, "R9");
    push_seg(1'b1, 5, "R9");
    push_seg(1'b0, 5, "R9");
    ticks(1, 1);
    wr(2'd0, 8'd10);
    wr(2'd0, 8'd0);
    ticks(16, 1);
    finish_run("R9");

    // R8 control resets the byte sequencer
    mon_en = 1'b0;
    wr(2'd3, 8'h36);
    wr(2'd0, 8'h09);
    start_count(4, 8'h36);
    expect_wave(4, 1, "R8");
    ticks(4, 1);
    finish_run("R8");

    // R8 stop while low
    start_count(4, 8'h36);
    mon_en = 1'b0;
    ticks(3, 1);
    #1 check(wave_out === 1'b0, "R8", "wave low before stop", int'(wave_out), 0);
    wr(2'd3, 8'h36);
    check(wave_out === 1'b1, "R8", "wave forced high", int'(wave_out), 1);
    tick_seen = 0;
    ticks(10, 1);
    #1;
    check(wave_out === 1'b1, "R8", "wave stays high after stop", int'(wave_out), 1);
    check(tick_seen == 0, "R8", "ticks after stop", tick_seen, 0);

    // R7 zero count is the full range
    start_count(0, 8'h36);
    expect_wave(0, 1, "R7");
    burst(65536);
    finish_run("R7");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule